// File: doc/BRIEF.md
# AC-link Output Frame Receiver

This block is the codec-side front end for the controller-to-codec direction of an AC'97-style serial link. It runs on the link bit clock and samples the serial data line on each rising edge. A rising edge on the frame sync line marks the first bit of a frame. The frame is a 16-bit tag slot followed by twelve 20-bit data slots, and each slot is sent most significant bit first.

Once the tag slot has been assembled, the block decides which of the later slots are meant for this codec. The decision depends on the configured link mode (primary, or one of three secondary modes) and on the configured codec ID. In primary mode the per-slot tag bits qualify the two command slots and two audio slots. In a secondary mode the command slots are accepted on a codec ID match instead, and the audio slots move to a mode-specific pair. Accepted command words and audio samples are registered onto the outputs, each with a one-cycle valid strobe. The downstream register file and converters consume them there.

Top module: `aclink_out_rx`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, every valid strobe is 0. After reset every data output reads 0.
- R2: A frame starts at the bit sampled on the first clock edge where sync is 1 and was 0 at the previous edge. Bit 0 is tag bit 15. Bits 0..15 are the tag, MSB first. Slot n (n = 1..12) occupies bits 16+20(n-1) to 35+20(n-1), MSB first. Data sampled after bit 255 and before the next sync rise is ignored. Sync remaining high does not restart the frame.
- R3: When tag bit 15 is 0, no valid strobe is raised for any slot of that frame.
- R4: With mode 00 (primary), tag bit 14 accepts slot 1 as the command address word, bit 13 accepts slot 2 as the command data word, bit 12 accepts slot 3 as the left sample and bit 11 accepts slot 4 as the right sample. All of these also require tag bits 1:0 to equal 00.
- R5: With mode 01, 10 or 11 (secondary), tag bits 14 and 13 have no effect. Slots 1 and 2 are both accepted exactly when tag bits 1:0 equal the configured codec ID. Audio slots are accepted only under that same match.
- R6: Secondary mode 01 takes left and right audio from slots 3 and 4 (tag bits 12 and 11). Mode 10 takes them from slots 7 and 8 (tag bits 8 and 7). Mode 11 takes left from slot 6 (tag bit 9) and right from slot 9 (tag bit 6).
- R7: A command output carries the full 20-bit slot word. An audio sample output carries slot bits 19:2.
- R8: A valid strobe is high for exactly the one cycle after the clock edge that samples the last bit of its slot. Each data output keeps its value while its strobe is low.
- R9: Tag bits outside the frame-valid bit, the codec ID and the tag bits of the slots selected by the current mode have no effect on any output.
- R10: A sync rise in the middle of a frame abandons that frame and restarts bit counting at tag bit 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link bit clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sync_i | input | 1 | Frame sync; a rising edge marks tag bit 15 |
| sdata_i | input | 1 | Serial output-frame data |
| mode_i | input | 2 | 00 primary, 01/10/11 secondary mode 1/2/3 |
| codec_id_i | input | 2 | This codec's ID for secondary modes |
| cmd_addr_o | output | 20 | Accepted slot 1 word |
| cmd_addr_vld_o | output | 1 | Strobe for cmd_addr_o |
| cmd_data_o | output | 20 | Accepted slot 2 word |
| cmd_data_vld_o | output | 1 | Strobe for cmd_data_o |
| left_o | output | 18 | Accepted left audio sample |
| left_vld_o | output | 1 | Strobe for left_o |
| right_o | output | 18 | Accepted right audio sample |
| right_vld_o | output | 1 | Strobe for right_o |

## Verification
The hardest case to reach is a sync rise that arrives partway through a frame. A design that ignores it keeps its old bit count, so the next frame's slots are misaligned without anything looking wrong at the ports. The stimulus sends a truncated frame whose tag is marked invalid and then, with no gap, a complete frame that carries random slot contents. Every accepted word of the second frame must then match bit for bit. Secondary mode 11 also gets close attention, because its audio pair is neither adjacent nor in ascending tag order. Frames that set the ignored tag bits are mixed in, and any stray strobe they raise counts as a miscompare.

// File: rtl/aclink_rx_pkg.sv
// Package: shared constants and types for the AC-link output frame receiver.
// Assumes a frame of one tag slot followed by a fixed count of data slots.
package aclink_rx_pkg;

    localparam int TAG_BITS    = 16;
    localparam int SLOT_BITS   = 20;
    localparam int DATA_SLOTS  = 12;
    localparam int SAMPLE_BITS = 18;
    localparam int ID_BITS     = 2;

    typedef enum logic [1:0] {
        MODE_PRIMARY = 2'b00,
        MODE_SEC1    = 2'b01,
        MODE_SEC2    = 2'b10,
        MODE_SEC3    = 2'b11
    } link_mode_e;

    // Left audio slot number for a link mode
    function automatic int left_slot_of(input link_mode_e m);
        case (m)
            MODE_SEC2: return 7;
            MODE_SEC3: return 6;
            default:   return 3;
        endcase
    endfunction

    // Right audio slot number for a link mode
    function automatic int right_slot_of(input link_mode_e m);
        case (m)
            MODE_SEC2: return 8;
            MODE_SEC3: return 9;
            default:   return 4;
        endcase
    endfunction

endpackage

// File: rtl/aclink_framer.sv
// Framer: detects the sync rising edge and tracks slot index and bit position.
// Assumes the sync rise coincides with the first tag bit. A new rise always
// restarts the frame. After the last data slot the framer idles until the next rise.
module aclink_framer #(
    parameter int TAG_W     = 16,
    parameter int SLOT_W    = 20,
    parameter int NUM_SLOTS = 12,
    localparam int IDX_W    = $clog2(NUM_SLOTS + 1),
    localparam int BIT_W    = $clog2((TAG_W > SLOT_W) ? TAG_W : SLOT_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sync_i,
    output logic             bit_en_o,
    output logic             slot_end_o,
    output logic [IDX_W-1:0] slot_idx_o
);

    logic             sync_q;
    logic             active_q;
    logic [IDX_W-1:0] nslot_q;
    logic [BIT_W-1:0] nbit_q;
    logic             sync_rise;
    logic [IDX_W-1:0] cur_slot;
    logic [BIT_W-1:0] cur_bit;
    logic [BIT_W-1:0] last_bit;
    logic             at_last;

    // Position of the bit sampled at this edge
    always_comb begin
        sync_rise = sync_i & ~sync_q;
        cur_slot  = sync_rise ? '0 : nslot_q;
        cur_bit   = sync_rise ? '0 : nbit_q;
        last_bit  = (cur_slot == '0) ? BIT_W'(TAG_W - 1) : BIT_W'(SLOT_W - 1);
        at_last   = (cur_bit == last_bit);
    end

    assign bit_en_o   = sync_rise | active_q;
    assign slot_end_o = bit_en_o & at_last;
    assign slot_idx_o = cur_slot;

    // Advance the frame position on each accepted bit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q   <= 1'b0;
            active_q <= 1'b0;
            nslot_q  <= '0;
            nbit_q   <= '0;
        end else begin
            sync_q <= sync_i;
            if (bit_en_o) begin
                if (at_last) begin
                    nslot_q  <= cur_slot + 1'b1;
                    nbit_q   <= '0;
                    active_q <= (cur_slot != IDX_W'(NUM_SLOTS));
                end else begin
                    nslot_q  <= cur_slot;
                    nbit_q   <= cur_bit + 1'b1;
                    active_q <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/aclink_shifter.sv
// Shifter: MSB-first serial-to-parallel register for one slot.
// The output word includes the bit being sampled now, so it is complete
// in the same cycle the framer flags the end of a slot.
module aclink_shifter #(
    parameter int SLOT_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_en_i,
    input  logic              sdata_i,
    output logic [SLOT_W-1:0] word_o
);

    logic [SLOT_W-2:0] sh_q;

    assign word_o = {sh_q, sdata_i};

    // Shift in one serial bit per enabled edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q <= '0;
        end else if (bit_en_i) begin
            sh_q <= word_o[SLOT_W-2:0];
        end
    end

endmodule

// File: rtl/aclink_slot_select.sv
// Slot selector: from the captured tag, link mode and codec ID, decides which
// command and audio slots this codec accepts. Purely combinational.
// Assumes the tag bit for slot n sits at position TAG_W-1-n.
module aclink_slot_select
    import aclink_rx_pkg::*;
#(
    parameter int TAG_W     = 16,
    parameter int NUM_SLOTS = 12,
    parameter int ID_W      = 2,
    localparam int IDX_W    = $clog2(NUM_SLOTS + 1)
) (
    input  link_mode_e       mode_i,
    input  logic [ID_W-1:0]  codec_id_i,
    input  logic [TAG_W-1:0] tag_i,
    output logic             take_addr_o,
    output logic             take_data_o,
    output logic             take_left_o,
    output logic             take_right_o,
    output logic [IDX_W-1:0] left_slot_o,
    output logic [IDX_W-1:0] right_slot_o
);

    logic [NUM_SLOTS:1] slot_flag;
    logic               frame_ok;
    logic               primary;
    logic               id_ok;

    // Per-slot valid flag picked out of the tag
    for (genvar s = 1; s <= NUM_SLOTS; s++) begin : g_flag
        assign slot_flag[s] = tag_i[TAG_W-1-s];
    end

    // Acceptance decision for the command and audio slots
    always_comb begin
        frame_ok     = tag_i[TAG_W-1];
        primary      = (mode_i == MODE_PRIMARY);
        id_ok        = primary ? (tag_i[ID_W-1:0] == '0)
                               : (tag_i[ID_W-1:0] == codec_id_i);
        left_slot_o  = IDX_W'(left_slot_of(mode_i));
        right_slot_o = IDX_W'(right_slot_of(mode_i));
        take_addr_o  = frame_ok & id_ok & (primary ? slot_flag[1] : 1'b1);
        take_data_o  = frame_ok & id_ok & (primary ? slot_flag[2] : 1'b1);
        take_left_o  = frame_ok & id_ok & slot_flag[left_slot_of(mode_i)];
        take_right_o = frame_ok & id_ok & slot_flag[right_slot_of(mode_i)];
    end

endmodule

// File: rtl/aclink_out_rx.sv
// Top: AC-link output frame receiver. Frames the serial line, captures the tag,
// and registers accepted command words and audio samples with one-cycle strobes.
// Assumes mode_i and codec_id_i change only between frames.
module aclink_out_rx
    import aclink_rx_pkg::*;
#(
    parameter int TAG_W     = TAG_BITS,
    parameter int SLOT_W    = SLOT_BITS,
    parameter int NUM_SLOTS = DATA_SLOTS,
    parameter int SAMPLE_W  = SAMPLE_BITS,
    parameter int ID_W      = ID_BITS,
    localparam int IDX_W    = $clog2(NUM_SLOTS + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sync_i,
    input  logic                sdata_i,
    input  logic [1:0]          mode_i,
    input  logic [ID_W-1:0]     codec_id_i,
    output logic [SLOT_W-1:0]   cmd_addr_o,
    output logic                cmd_addr_vld_o,
    output logic [SLOT_W-1:0]   cmd_data_o,
    output logic                cmd_data_vld_o,
    output logic [SAMPLE_W-1:0] left_o,
    output logic                left_vld_o,
    output logic [SAMPLE_W-1:0] right_o,
    output logic                right_vld_o
);

    logic              bit_en;
    logic              slot_end;
    logic [IDX_W-1:0]  slot_idx;
    logic [SLOT_W-1:0] word;
    logic [TAG_W-1:0]  tag_q;
    logic              take_addr, take_data, take_left, take_right;
    logic [IDX_W-1:0]  left_slot, right_slot;
    link_mode_e        mode;

    assign mode = link_mode_e'(mode_i);

    aclink_framer #(
        .TAG_W     (TAG_W),
        .SLOT_W    (SLOT_W),
        .NUM_SLOTS (NUM_SLOTS)
    ) framer_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .sync_i     (sync_i),
        .bit_en_o   (bit_en),
        .slot_end_o (slot_end),
        .slot_idx_o (slot_idx)
    );

    aclink_shifter #(
        .SLOT_W (SLOT_W)
    ) shifter_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_en_i (bit_en),
        .sdata_i  (sdata_i),
        .word_o   (word)
    );

    aclink_slot_select #(
        .TAG_W     (TAG_W),
        .NUM_SLOTS (NUM_SLOTS),
        .ID_W      (ID_W)
    ) select_i (
        .mode_i       (mode),
        .codec_id_i   (codec_id_i),
        .tag_i        (tag_q),
        .take_addr_o  (take_addr),
        .take_data_o  (take_data),
        .take_left_o  (take_left),
        .take_right_o (take_right),
        .left_slot_o  (left_slot),
        .right_slot_o (right_slot)
    );

    // Latch the tag when slot 0 completes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tag_q <= '0;
        end else if (slot_end && slot_idx == '0) begin
            tag_q <= word[TAG_W-1:0];
        end
    end

    // Register accepted slot contents and raise single-cycle strobes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_addr_o     <= '0;
            cmd_data_o     <= '0;
            left_o         <= '0;
            right_o        <= '0;
            cmd_addr_vld_o <= 1'b0;
            cmd_data_vld_o <= 1'b0;
            left_vld_o     <= 1'b0;
            right_vld_o    <= 1'b0;
        end else begin
            cmd_addr_vld_o <= 1'b0;
            cmd_data_vld_o <= 1'b0;
            left_vld_o     <= 1'b0;
            right_vld_o    <= 1'b0;
            if (slot_end && slot_idx == IDX_W'(1) && take_addr) begin
                cmd_addr_o     <= word;
                cmd_addr_vld_o <= 1'b1;
            end
            if (slot_end && slot_idx == IDX_W'(2) && take_data) begin
                cmd_data_o     <= word;
                cmd_data_vld_o <= 1'b1;
            end
            if (slot_end && slot_idx == left_slot && take_left) begin
                left_o     <= word[SLOT_W-1 -: SAMPLE_W];
                left_vld_o <= 1'b1;
            end
            if (slot_end && slot_idx == right_slot && take_right) begin
                right_o     <= word[SLOT_W-1 -: SAMPLE_W];
                right_vld_o <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/aclink_out_rx_chk.sv
// Checker: temporal properties of the receiver, bound into the top module.
module aclink_out_rx_chk #(
    parameter int TAG_W    = 16,
    parameter int SLOT_W   = 20,
    parameter int SAMPLE_W = 18,
    parameter int ID_W     = 2,
    parameter int IDX_W    = 4
) (
    input logic                clk,
    input logic                rst_n,
    input logic [1:0]          mode_i,
    input logic [ID_W-1:0]     codec_id_i,
    input logic                slot_end,
    input logic [IDX_W-1:0]    slot_idx,
    input logic [TAG_W-1:0]    tag_q,
    input logic [SLOT_W-1:0]   cmd_addr_o,
    input logic                cmd_addr_vld_o,
    input logic [SLOT_W-1:0]   cmd_data_o,
    input logic                cmd_data_vld_o,
    input logic [SAMPLE_W-1:0] left_o,
    input logic                left_vld_o,
    input logic [SAMPLE_W-1:0] right_o,
    input logic                right_vld_o
);

    logic [3:0] vlds;
    assign vlds = {cmd_addr_vld_o, cmd_data_vld_o, left_vld_o, right_vld_o};

    a_r1_reset_quiet: assert property (@(posedge clk) !rst_n |=> vlds == 4'b0);

    a_r2_one_slot_at_a_time: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(vlds));

    a_r3_invalid_frame_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_end && slot_idx != '0 && !tag_q[TAG_W-1]) |=> vlds == 4'b0);

    // R5: a secondary codec ignores command slots addressed to another ID
    a_r5_id_mismatch_no_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_end && mode_i != 2'b00 && slot_idx == IDX_W'(1)
         && tag_q[ID_W-1:0] != codec_id_i) |=> !cmd_addr_vld_o);

    a_r8_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
        (vlds != 4'b0) |=> vlds == 4'b0);

    a_r8_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_addr_vld_o |-> $stable(cmd_addr_o));

    a_r8_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_data_vld_o |-> $stable(cmd_data_o));

    a_r8_left_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !left_vld_o |-> $stable(left_o));

    a_r8_right_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !right_vld_o |-> $stable(right_o));

endmodule

bind aclink_out_rx aclink_out_rx_chk #(
    .TAG_W    (TAG_W),
    .SLOT_W   (SLOT_W),
    .SAMPLE_W (SAMPLE_W),
    .ID_W     (ID_W),
    .IDX_W    (IDX_W)
) chk_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .mode_i         (mode_i),
    .codec_id_i     (codec_id_i),
    .slot_end       (slot_end),
    .slot_idx       (slot_idx),
    .tag_q          (tag_q),
    .cmd_addr_o     (cmd_addr_o),
    .cmd_addr_vld_o (cmd_addr_vld_o),
    .cmd_data_o     (cmd_data_o),
    .cmd_data_vld_o (cmd_data_vld_o),
    .left_o         (left_o),
    .left_vld_o     (left_vld_o),
    .right_o        (right_o),
    .right_vld_o    (right_vld_o)
);

// File: tb/aclink_out_rx_tb_top.sv
// Scoreboard bench: the driver pushes expected items, the monitor pops and compares them.
module aclink_out_rx_tb_top;

    localparam int K_ADDR  = 0;
    localparam int K_DATA  = 1;
    localparam int K_LEFT  = 2;
    localparam int K_RIGHT = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sync = 1'b0;
    logic        sdata = 1'b0;
    logic [1:0]  mode = 2'b00;
    logic [1:0]  cid = 2'b00;
    logic [19:0] cmd_addr, cmd_data;
    logic [17:0] left_s, right_s;
    logic        addr_v, data_v, left_v, right_v;

    int          n_checks = 0;
    int          n_fail = 0;
    logic [19:0] slot_v [1:12];
    int          exp_kind [$];
    logic [19:0] exp_val [$];
    string       exp_req [$];

    always #5 clk = ~clk;

    aclink_out_rx dut_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .sync_i         (sync),
        .sdata_i        (sdata),
        .mode_i         (mode),
        .codec_id_i     (cid),
        .cmd_addr_o     (cmd_addr),
        .cmd_addr_vld_o (addr_v),
        .cmd_data_o     (cmd_data),
        .cmd_data_vld_o (data_v),
        .left_o         (left_s),
        .left_vld_o     (left_v),
        .right_o        (right_s),
        .right_vld_o    (right_v)
    );

    task automatic check(input string req, input logic [19:0] got, input logic [19:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic push(input int k, input logic [19:0] v, input string req);
        exp_kind.push_back(k);
        exp_val.push_back(v);
        exp_req.push_back(req);
    endtask

    // Pop one expected item and compare it with an observed strobe
    task automatic pop_cmp(input int k, input logic [19:0] v);
        n_checks++;
        if (exp_kind.size() == 0) begin
            n_fail++;
            $display("FAIL R3/R9: unexpected strobe kind %0d value %h, expected none", k, v);
        end else begin
            int          ek = exp_kind.pop_front();
            logic [19:0] ev = exp_val.pop_front();
            string       er = exp_req.pop_front();
            if (ek != k || ev !== v) begin
                n_fail++;
                $display("FAIL %s: got kind %0d value %h, expected kind %0d value %h",
                         er, k, v, ek, ev);
            end
        end
    endtask

    // Monitor: compares every strobe against the scoreboard
    always @(negedge clk) begin
        if (rst_n) begin
            if (addr_v)  pop_cmp(K_ADDR, cmd_addr);
            if (data_v)  pop_cmp(K_DATA, cmd_data);
            if (left_v)  pop_cmp(K_LEFT, {2'b00, left_s});
            if (right_v) pop_cmp(K_RIGHT, {2'b00, right_s});
        end
    end

    function automatic logic bit_at(input logic [15:0] tag, input int i);
        if (i < 16) return tag[15 - i];
        return slot_v[(i - 16) / 20 + 1][19 - (i - 16) % 20];
    endfunction

    // Driver: fill slots, compute expected items from the requirements, drive bits
    task automatic send_frame(input logic [15:0] tag, input int nbits, input string req);
        bit prim = (mode == 2'b00);
        bit idm;
        int ls, rs;
        for (int s = 1; s <= 12; s++) slot_v[s] = 20'($urandom);
        idm = prim ? (tag[1:0] == 2'b00) : (tag[1:0] == cid);
        ls = (mode == 2'b10) ? 7 : (mode == 2'b11) ? 6 : 3;
        rs = (mode == 2'b10) ? 8 : (mode == 2'b11) ? 9 : 4;
        if (nbits == 256 && tag[15] && idm) begin
            for (int s = 1; s <= 12; s++) begin
                if (s == 1 && (!prim || tag[14])) push(K_ADDR, slot_v[1], req);
                if (s == 2 && (!prim || tag[13])) push(K_DATA, slot_v[2], req);
                if (s == ls && tag[15 - ls]) push(K_LEFT, {2'b00, slot_v[s][19:2]}, req);
                if (s == rs && tag[15 - rs]) push(K_RIGHT, {2'b00, slot_v[s][19:2]}, req);
            end
        end
        for (int i = 0; i < nbits; i++) begin
            @(negedge clk);
            sync  <= (i < 16);
            sdata <= bit_at(tag, i);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) begin
            @(negedge clk);
            sync  <= 1'b0;
            sdata <= 1'($urandom);
        end
    endtask

    task automatic drain(input string req);
        idle(30);
        check(req, 20'(exp_kind.size()), 20'd0);
        exp_kind.delete();
        exp_val.delete();
        exp_req.delete();
    endtask

    task automatic finish_run;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n <= 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1", {16'b0, addr_v, data_v, left_v, right_v}, 20'd0);
        check("R1", cmd_addr, 20'd0);
        check("R1", cmd_data, 20'd0);
        check("R1", {2'b00, left_s}, 20'd0);
        check("R1", {2'b00, right_s}, 20'd0);
        idle(3);

        // R4 R7 R2: primary, all four slots
        mode = 2'b00; cid = 2'b00;
        send_frame(16'hF800, 256, "R4");
        drain("R4");
        // R8: outputs hold after the strobes
        check("R8", cmd_addr, slot_v[1]);
        check("R8", {2'b00, right_s}, {2'b00, slot_v[4][19:2]});

        // R3: frame-valid bit clear
        send_frame(16'h7800, 256, "R3");
        drain("R3");
        // R4: primary left only, and primary with nonzero ID
        send_frame(16'h9000, 256, "R4");
        drain("R4");
        send_frame(16'hF801, 256, "R4");
        drain("R4");
        // R9: primary with secondary-only tag bits set
        send_frame(16'hA3C0, 256, "R9");
        drain("R9");

        // R5 R6: secondary 1, matching ID, bits 14/13 clear
        mode = 2'b01; cid = 2'b10;
        send_frame(16'h9802, 256, "R5");
        drain("R5");
        // R5: ID mismatch
        send_frame(16'hF803, 256, "R5");
        drain("R5");

        // R6 R9: secondary 2, slots 7/8, with bits 12/11 set
        mode = 2'b10; cid = 2'b01;
        send_frame(16'h9981, 256, "R6");
        drain("R6");
        send_frame(16'h8081, 256, "R6");
        drain("R6");

        // R6: secondary 3, slots 6 and 9
        mode = 2'b11; cid = 2'b11;
        send_frame(16'h8243, 256, "R6");
        drain("R6");
        send_frame(16'h8203, 256, "R6");
        drain("R6");

        // R10: truncated frame then restart without gap
        mode = 2'b00; cid = 2'b00;
        send_frame(16'h7800, 100, "R10");
        send_frame(16'hF800, 256, "R10");
        drain("R10");
        check("R10", cmd_data, slot_v[2]);

        finish_run();
    end

endmodule